// File: doc/BRIEF.md
# Accumulator Processor with Register-Transfer Fetch

This block is a small processor built around one accumulator. Instructions and data share a single memory, and the block reaches that memory through one synchronous port. Every instruction is fetched as explicit register transfers. The program counter goes into the address register. The word that comes back is captured in the data register. That word is then moved into the current-instruction register. The operand word is fetched the same way, and then the instruction executes.

An instruction is two 8-bit words: an opcode followed by an operand. The operand is read in one of three ways:
- as the data value itself (immediate),
- as a memory address (direct),
- as a base address to which the index register is added, modulo 256 (indexed).

The memory port is synchronous. Read data appears one cycle after the address is presented. A write takes effect at the clock edge during which the write enable is high. The processor starts at address 0 after reset and runs until it meets an end or undefined opcode. It then raises `halted` and stays stopped.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, `halted` is 0, `mem_we` is 0 and `mem_addr` is 0. After reset, execution starts at address 0.
- R2: Fetch uses three transfers per word: address register ← PC, then data register ← memory word (one cycle later), then instruction register ← data register. PC increments once per fetched word. An immediate-mode instruction takes 7 cycles in total.
- R3: LDM (opcode 0x01) loads the operand into ACC. ADDI (0x06) adds the operand to ACC modulo 256.
- R4: LDD (0x02) loads ACC from the memory word at the operand address. ADDD (0x07) adds that word to ACC. Each takes 9 cycles.
- R5: LDR (0x04) loads IX with the operand. LDX (0x03) loads ACC from address (operand + IX) modulo 256.
- R6: STO (0x05) writes ACC to the operand address with `mem_we` high for exactly one cycle. It takes 8 cycles.
- R7: INC (0x08) adds one to ACC, wrapping 0xFF to 0x00. Its operand is ignored.
- R8: AND (0x09), OR (0x0A) and XOR (0x0B) combine ACC with the immediate operand and write the result to ACC.
- R9: LSL (0x0C) and LSR (0x0D) shift ACC by the operand count and fill with zeros. A count of 8 or more gives 0.
- R10: CMP (0x0E) sets the equal flag when ACC equals the operand and leaves ACC unchanged. Only CMP changes the flag. JPE (0x10) branches to the operand when the flag is set, and JPN (0x11) branches when it is clear.
- R11: JMP (0x0F) always branches to the operand address.
- R12: END (0x00) raises `halted` 7 cycles after its fetch begins. After that, `halted` stays high and no memory write occurs.
- R13: Any opcode at or above 0x12 halts the processor in the same way as END.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Memory address, always the address register |
| mem_wdata | output | DW | Write data, always ACC |
| mem_rdata | input | DW | Read data, valid one cycle after the address |
| mem_we | output | 1 | Write enable |
| halted | output | 1 | High once execution has stopped |

## Verification
Instruction costs are fixed: 7 cycles for immediate, jump and compare instructions, 8 for a store and 9 for a memory load or add. An end opcode raises `halted` 7 cycles after its fetch begins. The bench counts clock edges from reset release until `halted` rises and compares the total with the sum for the program. This checks the fetch step count without probing any internal register. Results are read from the bench memory after the halt, and all outputs are sampled on the falling edge, so each value is taken after the register stage that produced it.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          halted
);

  localparam logic [DW-1:0] OP_END  = DW'(8'h00);
  localparam logic [DW-1:0] OP_LDM  = DW'(8'h01);
  localparam logic [DW-1:0] OP_LDD  = DW'(8'h02);
  localparam logic [DW-1:0] OP_LDX  = DW'(8'h03);
  localparam logic [DW-1:0] OP_LDR  = DW'(8'h04);
  localparam logic [DW-1:0] OP_STO  = DW'(8'h05);
  localparam logic [DW-1:0] OP_ADDI = DW'(8'h06);
  localparam logic [DW-1:0] OP_ADDD = DW'(8'h07);
  localparam logic [DW-1:0] OP_INC  = DW'(8'h08);
  localparam logic [DW-1:0] OP_AND  = DW'(8'h09);
  localparam logic [DW-1:0] OP_OR   = DW'(8'h0A);
  localparam logic [DW-1:0] OP_XOR  = DW'(8'h0B);
  localparam logic [DW-1:0] OP_LSL  = DW'(8'h0C);
  localparam logic [DW-1:0] OP_LSR  = DW'(8'h0D);
  localparam logic [DW-1:0] OP_CMP  = DW'(8'h0E);
  localparam logic [DW-1:0] OP_JMP  = DW'(8'h0F);
  localparam logic [DW-1:0] OP_JPE  = DW'(8'h10);
  localparam logic [DW-1:0] OP_JPN  = DW'(8'h11);

  typedef enum logic [3:0] {
    S_F1, S_F2, S_F3, S_F4, S_O2, S_O3, S_EX, S_RD, S_WB, S_ST, S_HALT
  } state_t;

  state_t        state;
  logic [AW-1:0] pc, mar, ix;
  logic [DW-1:0] mdr, cir, acc;
  logic          eq;

  assign mem_addr  = mar;
  assign mem_wdata = acc;
  assign mem_we    = (state == S_ST);
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_F1;
      pc    <= '0;
      mar   <= '0;
      ix    <= '0;
      mdr   <= '0;
      cir   <= '0;
      acc   <= '0;
      eq    <= 1'b0;
    end else begin
      case (state)
        S_F1: begin
          mar   <= pc;
          state <= S_F2;
        end
        S_F2: state <= S_F3;
        S_F3: begin
          mdr   <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_F4;
        end
        S_F4: begin
          cir   <= mdr;
          mar   <= pc;
          state <= S_O2;
        end
        S_O2: state <= S_O3;
        S_O3: begin
          mdr   <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= S_EX;
        end
        S_EX: begin
          state <= S_F1;
          case (cir)
            OP_END:  state <= S_HALT;
            OP_LDM:  acc <= mdr;
            OP_LDD, OP_ADDD: begin
              mar   <= mdr[AW-1:0];
              state <= S_RD;
            end
            OP_LDX: begin
              mar   <= mdr[AW-1:0] + ix;
              state <= S_RD;
            end
            OP_LDR:  ix  <= mdr[AW-1:0];
            OP_STO: begin
              mar   <= mdr[AW-1:0];
              state <= S_ST;
            end
            OP_ADDI: acc <= acc + mdr;
            OP_INC:  acc <= acc + 1'b1;
            OP_AND:  acc <= acc & mdr;
            OP_OR:   acc <= acc | mdr;
            OP_XOR:  acc <= acc ^ mdr;
            OP_LSL:  acc <= acc << mdr;
            OP_LSR:  acc <= acc >> mdr;
            OP_CMP:  eq  <= (acc == mdr);
            OP_JMP:  pc  <= mdr[AW-1:0];
            OP_JPE:  if (eq)  pc <= mdr[AW-1:0];
            OP_JPN:  if (!eq) pc <= mdr[AW-1:0];
            default: state <= S_HALT;
          endcase
        end
        S_RD: state <= S_WB;
        S_WB: begin
          acc   <= (cir == OP_ADDD) ? acc + mem_rdata : mem_rdata;
          state <= S_F1;
        end
        S_ST:   state <= S_F1;
        S_HALT: state <= S_HALT;
        default: state <= S_HALT;
      endcase
    end
  end

  AST_MAR_TAKES_PC:  assert property (@(posedge clk) disable iff (rst) state == S_F1 |=> mar == $past(pc)); // R2
  AST_MDR_TAKES_MEM: assert property (@(posedge clk) disable iff (rst) state == S_F3 |=> mdr == $past(mem_rdata)); // R2
  AST_CIR_TAKES_MDR: assert property (@(posedge clk) disable iff (rst) state == S_F4 |=> cir == $past(mdr)); // R2
  AST_PC_STEPS:      assert property (@(posedge clk) disable iff (rst) state == S_F3 |=> pc == AW'($past(pc) + 1'b1)); // R2
  AST_WE_SINGLE:     assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R6
  AST_INC_ADDS_ONE:  assert property (@(posedge clk) disable iff (rst) (state == S_EX && cir == OP_INC) |=> acc == DW'($past(acc) + 1'b1)); // R7
  AST_FLAG_ONLY_CMP: assert property (@(posedge clk) disable iff (rst) !(state == S_EX && cir == OP_CMP) |=> $stable(eq)); // R10
  AST_HALT_STICKY:   assert property (@(posedge clk) disable iff (rst) halted |=> halted && !mem_we); // R12

endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, halted;
  logic [7:0] mem [0:255];
  int         wr_count = 0;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
  endtask

  task automatic ins(input int a, input logic [7:0] op, input logic [7:0] arg);
    mem[a]     = op;
    mem[a + 1] = arg;
  endtask

  task automatic run(output int cyc);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr_count = 0;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 halted in reset", halted, 0);
    chk("R1 we in reset", mem_we, 0);
    chk("R1 addr in reset", mem_addr, 0);
  endtask

  task automatic t_store_timing();
    int c;
    clear_mem();
    ins(0, 8'h00, 8'h00);
    run(c);
    chk("R12 END alone halts after 7", c, 7);
    clear_mem();
    ins(0, 8'h01, 8'h05);
    ins(2, 8'h00, 8'h00);
    run(c);
    chk("R2 LDM+END cycles", c, 14);
    clear_mem();
    ins(0, 8'h01, 8'h05);
    ins(2, 8'h05, 8'h80);
    ins(4, 8'h00, 8'h00);
    run(c);
    chk("R6 STO cycles", c, 22);
    chk("R3 LDM value stored", mem[8'h80], 8'h05);
    chk("R6 one write pulse", wr_count, 1);
  endtask

  task automatic t_direct();
    int c;
    clear_mem();
    mem[8'h90] = 8'h21;
    mem[8'h91] = 8'h10;
    ins(0, 8'h02, 8'h90);
    ins(2, 8'h07, 8'h91);
    ins(4, 8'h05, 8'hA0);
    ins(6, 8'h06, 8'h05);
    ins(8, 8'h05, 8'hA1);
    ins(10, 8'h00, 8'h00);
    run(c);
    chk("R4 direct load/add cycles", c, 9 + 9 + 8 + 7 + 8 + 7);
    chk("R4 LDD+ADDD result", mem[8'hA0], 8'h31);
    chk("R3 ADDI result", mem[8'hA1], 8'h36);
  endtask

  task automatic t_index();
    int c;
    clear_mem();
    mem[8'h93] = 8'h5A;
    ins(0, 8'h04, 8'h03);
    ins(2, 8'h03, 8'h90);
    ins(4, 8'h05, 8'hA0);
    ins(6, 8'h00, 8'h00);
    run(c);
    chk("R5 indexed load", mem[8'hA0], 8'h5A);
    clear_mem();
    mem[8'h10] = 8'h77;
    ins(0, 8'h04, 8'h20);
    ins(2, 8'h03, 8'hF0);
    ins(4, 8'h05, 8'hA2);
    ins(6, 8'h00, 8'h00);
    run(c);
    chk("R5 indexed address wraps", mem[8'hA2], 8'h77);
  endtask

  task automatic t_inc();
    int c;
    clear_mem();
    ins(0, 8'h01, 8'hFE);
    ins(2, 8'h08, 8'h00);
    ins(4, 8'h05, 8'hA0);
    ins(6, 8'h08, 8'h55);
    ins(8, 8'h05, 8'hA1);
    ins(10, 8'h00, 8'h00);
    run(c);
    chk("R7 INC", mem[8'hA0], 8'hFF);
    chk("R7 INC wraps, operand ignored", mem[8'hA1], 8'h00);
  endtask

  task automatic t_mask();
    int c;
    clear_mem();
    ins(0, 8'h01, 8'hF3);
    ins(2, 8'h09, 8'h0F);
    ins(4, 8'h05, 8'hA0);
    ins(6, 8'h0A, 8'hA0);
    ins(8, 8'h05, 8'hA1);
    ins(10, 8'h0B, 8'hFF);
    ins(12, 8'h05, 8'hA2);
    ins(14, 8'h00, 8'h00);
    run(c);
    chk("R8 AND", mem[8'hA0], 8'h03);
    chk("R8 OR", mem[8'hA1], 8'hA3);
    chk("R8 XOR", mem[8'hA2], 8'h5C);
  endtask

  task automatic t_shift();
    int c;
    clear_mem();
    ins(0, 8'h01, 8'h16);
    ins(2, 8'h0C, 8'h03);
    ins(4, 8'h05, 8'hA0);
    ins(6, 8'h0D, 8'h01);
    ins(8, 8'h05, 8'hA1);
    ins(10, 8'h01, 8'h81);
    ins(12, 8'h0C, 8'h08);
    ins(14, 8'h05, 8'hA2);
    ins(16, 8'h01, 8'h81);
    ins(18, 8'h0D, 8'h07);
    ins(20, 8'h05, 8'hA3);
    ins(22, 8'h00, 8'h00);
    run(c);
    chk("R9 LSL 3", mem[8'hA0], 8'hB0);
    chk("R9 LSR 1", mem[8'hA1], 8'h58);
    chk("R9 LSL 8 gives zero", mem[8'hA2], 8'h00);
    chk("R9 LSR 7 zero fill", mem[8'hA3], 8'h01);
  endtask

  task automatic t_branch();
    int c;
    clear_mem();
    ins(8'h00, 8'h01, 8'h07);
    ins(8'h02, 8'h0E, 8'h07);
    ins(8'h04, 8'h10, 8'h0A);
    ins(8'h06, 8'h01, 8'hEE);
    ins(8'h08, 8'h00, 8'h00);
    ins(8'h0A, 8'h05, 8'hA0);
    ins(8'h0C, 8'h0E, 8'h08);
    ins(8'h0E, 8'h10, 8'h14);
    ins(8'h10, 8'h01, 8'h11);
    ins(8'h12, 8'h11, 8'h18);
    ins(8'h14, 8'h05, 8'hA1);
    ins(8'h16, 8'h00, 8'h00);
    ins(8'h18, 8'h05, 8'hA2);
    ins(8'h1A, 8'h0F, 8'h20);
    ins(8'h1C, 8'h05, 8'hA3);
    ins(8'h1E, 8'h00, 8'h00);
    ins(8'h20, 8'h08, 8'h00);
    ins(8'h22, 8'h05, 8'hA4);
    ins(8'h24, 8'h00, 8'h00);
    run(c);
    chk("R10 JPE taken, CMP keeps ACC", mem[8'hA0], 8'h07);
    chk("R10 JPE not taken / JPN taken", mem[8'hA1], 8'h00);
    chk("R10 JPN target reached", mem[8'hA2], 8'h11);
    chk("R11 JMP skips", mem[8'hA3], 8'h00);
    chk("R11 JMP target reached", mem[8'hA4], 8'h12);
  endtask

  task automatic t_undef();
    int c;
    int w;
    clear_mem();
    ins(0, 8'h01, 8'h3C);
    ins(2, 8'h05, 8'hA0);
    ins(4, 8'h7E, 8'h00);
    ins(6, 8'h05, 8'hA1);
    ins(8, 8'h00, 8'h00);
    run(c);
    chk("R13 undefined halts, cycles", c, 22);
    chk("R13 prior store done", mem[8'hA0], 8'h3C);
    chk("R13 no execution after", mem[8'hA1], 8'h00);
    w = wr_count;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R12 halted stays high", halted, 1);
    chk("R12 no write after halt", wr_count, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_store_timing();
    t_direct();
    t_index();
    t_inc();
    t_mask();
    t_shift();
    t_branch();
    t_undef();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule